// File: doc/BRIEF.md
# Register Write-Protection Unlock Guard

This guard sits on the write side of a small bank of memory-mapped control registers. It watches every write on a simple address/data bus and lets a write through to the protected bank only while it is unlocked. Software unlocks it by writing an ordered four-word key into a dedicated command register, and locks it again by writing zero to that same register.

The guard tracks how far the key has progressed, aborts the attempt when a wrong value or an unrelated write arrives, and drops blocked writes while raising a sticky error flag. The write-enable toward the protected bank is combinational, so an allowed write lands in the same cycle it appears on the bus. Software may unlock once and issue a burst of writes, or wrap each single write in unlock and relock; both patterns behave the same way.

Top module: `wp_unlock_guard`

## Requirements
- R1: After a synchronous active-low reset, `unlocked` is 0, `prot_err` is 0 and `reg_wr_en` is 0.
- R2: Four consecutive writes to the command register (address `CMD_ADDR`, default 0) carrying 0x000000A5, 0x00000001, 0x0000FFFE, 0x00000001 in that order set `unlocked` to 1 in the cycle after the fourth write.
- R3: While unlocked, a nonzero write to the command register leaves `unlocked` at 1.
- R4: A write of 0x00000000 to the command register sets `unlocked` to 0 in the next cycle and returns key progress to the first word, whether the guard was unlocked or part way through the key.
- R5: While locked, a nonzero command write that differs from the next expected key word returns progress to the first word, even when the value equals an earlier key word.
- R6: While locked, a write to any address other than the command register keeps `reg_wr_en` at 0, returns key progress to the first word, and sets `prot_err` in the next cycle.
- R7: While unlocked, a write to any address other than the command register raises `reg_wr_en` in the same cycle and leaves `prot_err` unchanged.
- R8: `prot_err` stays at 1 once set until the next reset.
- R9: A write to the command register never raises `reg_wr_en`.
- R10: Repeated unlock, single protected write, relock rounds each pass exactly their one protected write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe of the register bus |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 32 | Write data |
| reg_wr_en | output | 1 | Write enable toward the protected registers |
| unlocked | output | 1 | High while protected writes are allowed |
| prot_err | output | 1 | Sticky flag: a write was blocked |

## Verification
The properties assume a single-cycle write strobe with address and data valid whenever `bus_wr` is high, and that inputs are stable around the rising edge. The bench drives every input on the falling edge, holds each write for exactly one cycle, and returns the strobe to zero between stimulus groups, so each write is seen once. A behavioural model holding progress as an integer and the two flags as bits predicts all three outputs every cycle, including interrupted keys, repeated key words and aborts by unrelated writes.

// File: rtl/wp_guard_pkg.sv
// Package: shared constants and the key lookup for the write-protection guard.
// Assumes a 32-bit write data bus and a fixed four-word unlock key.
package wp_guard_pkg;

    localparam int DATA_W  = 32;
    localparam int KEY_LEN = 4;

    // Returns the expected key word for a given progress position.
    function automatic logic [DATA_W-1:0] key_word(input int idx);
        case (idx)
            0:       key_word = 32'h0000_00A5;
            1:       key_word = 32'h0000_0001;
            2:       key_word = 32'h0000_FFFE;
            default: key_word = 32'h0000_0001;
        endcase
    endfunction

endpackage

// File: rtl/wp_seq_tracker.sv
// Module: tracks progress through the unlock key and holds the unlocked state.
// Assumes cmd_wr and other_wr are mutually exclusive single-cycle strobes.
module wp_seq_tracker
    import wp_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              other_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);

    localparam int PW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(KEY_LEN - 1);

    logic [PW-1:0] progress;
    logic          key_hit;
    logic          is_zero;

    // Compare incoming data with the key word expected next.
    always_comb begin
        key_hit = (wdata == key_word(int'(progress)));
        is_zero = (wdata == '0);
    end

    // Advance, abort or relock the key sequence on each bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            progress <= '0;
            unlocked <= 1'b0;
        end else if (cmd_wr && is_zero) begin
            progress <= '0;
            unlocked <= 1'b0;
        end else if (cmd_wr && !unlocked) begin
            if (!key_hit) begin
                progress <= '0;
            end else if (progress == LAST) begin
                progress <= '0;
                unlocked <= 1'b1;
            end else begin
                progress <= progress + PW'(1);
            end
        end else if (other_wr && !unlocked) begin
            progress <= '0;
        end
    end

    p_unlock_after_last_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(cmd_wr && wdata == key_word(KEY_LEN - 1)));

    p_nonzero_keeps_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && cmd_wr && wdata != '0) |=> unlocked);

    p_zero_relocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata == '0) |=> (!unlocked && progress == '0));

    p_mismatch_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !unlocked && wdata != '0 && wdata != key_word(int'(progress)))
        |=> (!unlocked && progress == '0));

    p_foreign_write_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (other_wr && !unlocked) |=> (!unlocked && progress == '0));

endmodule

// File: rtl/wp_write_gate.sv
// Module: decodes the bus write, gates writes to the protected bank and keeps
// the sticky protection-error flag. Assumes address/data valid with bus_wr.
module wp_write_gate #(
    parameter int                 ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]  CMD_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              unlocked,
    output logic              cmd_wr,
    output logic              other_wr,
    output logic              reg_wr_en,
    output logic              prot_err
);

    // Split the write strobe into command and protected-bank writes.
    always_comb begin
        cmd_wr    = bus_wr && (bus_addr == CMD_ADDR);
        other_wr  = bus_wr && (bus_addr != CMD_ADDR);
        reg_wr_en = other_wr && unlocked;
    end

    // Record any protected-bank write dropped while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_err <= 1'b0;
        end else if (other_wr && !unlocked) begin
            prot_err <= 1'b1;
        end
    end

    p_blocked_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != CMD_ADDR && !unlocked) |=> prot_err);

    p_pass_when_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != CMD_ADDR && unlocked) |-> reg_wr_en);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> prot_err);

    p_cmd_never_passes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CMD_ADDR) |-> !reg_wr_en);

endmodule

// File: rtl/wp_unlock_guard.sv
// Module: top of the write-protection guard. Ties the bus decoder/gate to the
// key tracker. Assumes one write per strobe cycle and synchronous reset.
module wp_unlock_guard
    import wp_guard_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              reg_wr_en,
    output logic              unlocked,
    output logic              prot_err
);

    logic cmd_wr;
    logic other_wr;

    wp_write_gate #(
        .ADDR_W   (ADDR_W),
        .CMD_ADDR (CMD_ADDR)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .unlocked  (unlocked),
        .cmd_wr    (cmd_wr),
        .other_wr  (other_wr),
        .reg_wr_en (reg_wr_en),
        .prot_err  (prot_err)
    );

    wp_seq_tracker u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .other_wr (other_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!unlocked && !prot_err));

endmodule

// File: tb/tb_wp_unlock_guard.sv
module tb_wp_unlock_guard;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          reg_wr_en;
    logic          unlocked;
    logic          prot_err;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int          m_prog = 0;
    bit          m_unl  = 0;
    bit          m_err  = 0;
    logic [31:0] keys [4] = '{32'h0000_00A5, 32'h0000_0001, 32'h0000_FFFE, 32'h0000_0001};

    always #10 clk = ~clk;

    wp_unlock_guard #(.ADDR_W(AW), .CMD_ADDR('0)) dut (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
        .reg_wr_en, .unlocked, .prot_err
    );

    task automatic check_bit(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s = %0b expected %0b", tag, name, act, exp);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check_bit(tag, "unlocked", unlocked, 1'b0);
        check_bit(tag, "prot_err", prot_err, 1'b0);
        check_bit(tag, "reg_wr_en", reg_wr_en, 1'b0);
        m_prog = 0; m_unl = 0; m_err = 0;
        rst_n = 1'b1;
    endtask

    // One bus cycle: drive, compare all outputs with the model, update model.
    task automatic cyc(input string tag, input bit wr, input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = wr; bus_addr = AW'(addr); bus_wdata = data;
        #1;
        check_bit(tag, "reg_wr_en", reg_wr_en, wr && addr != 0 && m_unl);
        check_bit(tag, "unlocked", unlocked, m_unl);
        check_bit(tag, "prot_err", prot_err, m_err);
        if (wr) begin
            if (addr == 0) begin
                if (data == 0) begin
                    m_unl = 0; m_prog = 0;
                end else if (!m_unl) begin
                    if (data == keys[m_prog]) begin
                        if (m_prog == 3) begin m_unl = 1; m_prog = 0; end
                        else m_prog++;
                    end else m_prog = 0;
                end
            end else if (!m_unl) begin
                m_err = 1; m_prog = 0;
            end
        end
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 32'h0);
    endtask

    task automatic send_key(input string tag);
        for (int i = 0; i < 4; i++) cyc(tag, 1, 0, keys[i]);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset("R1");
        idle("R1");

        // R2: full key unlocks the cycle after the last word
        send_key("R2");
        idle("R2");
        check_bit("R2", "unlocked after key", unlocked, 1'b1);

        // R7: protected write passes while unlocked; R9: command writes never pass
        cyc("R7", 1, 8'h10, 32'h1234);
        cyc("R7", 1, 8'h14, 32'h5678);
        cyc("R9", 1, 0, 32'h0000_00A5);
        // R3: nonzero command writes keep it unlocked
        cyc("R3", 1, 0, 32'hDEAD_BEEF);
        idle("R3");
        check_bit("R3", "unlocked kept", unlocked, 1'b1);

        // R4: zero relocks
        cyc("R4", 1, 0, 32'h0);
        idle("R4");
        check_bit("R4", "unlocked after zero", unlocked, 1'b0);

        // R6: blocked write sets sticky error; R8 sticky over idles
        cyc("R6", 1, 8'h20, 32'hAAAA);
        idle("R6");
        check_bit("R6", "prot_err set", prot_err, 1'b1);
        repeat (3) idle("R8");
        check_bit("R8", "prot_err held", prot_err, 1'b1);

        // R5: repeated earlier key word mid-sequence restarts progress
        cyc("R5", 1, 0, keys[0]);
        cyc("R5", 1, 0, keys[1]);
        cyc("R5", 1, 0, keys[0]);
        cyc("R5", 1, 0, keys[1]);
        cyc("R5", 1, 0, keys[2]);
        cyc("R5", 1, 0, keys[3]);
        idle("R5");
        check_bit("R5", "still locked", unlocked, 1'b0);
        cyc("R5", 1, 0, 32'h0000_1111);
        send_key("R5");
        idle("R5");
        check_bit("R5", "unlock after restart", unlocked, 1'b1);
        cyc("R4", 1, 0, 32'h0);

        // R4: zero during a partial key restarts it
        cyc("R4", 1, 0, keys[0]);
        cyc("R4", 1, 0, keys[1]);
        cyc("R4", 1, 0, 32'h0);
        cyc("R4", 1, 0, keys[2]);
        cyc("R4", 1, 0, keys[3]);
        idle("R4");
        check_bit("R4", "partial key discarded", unlocked, 1'b0);

        // R6: foreign write mid-key aborts it
        cyc("R6", 1, 0, keys[0]);
        cyc("R6", 1, 0, keys[1]);
        cyc("R6", 1, 8'h30, 32'h1);
        cyc("R6", 1, 0, keys[2]);
        cyc("R6", 1, 0, keys[3]);
        idle("R6");
        check_bit("R6", "aborted key stays locked", unlocked, 1'b0);

        // R10: unlock, single write, relock rounds
        for (int r = 0; r < 3; r++) begin
            send_key("R10");
            cyc("R10", 1, 8'h40 + r, 32'(r));
            cyc("R10", 1, 0, 32'h0);
            idle("R10");
            check_bit("R10", "relocked after round", unlocked, 1'b0);
        end

        // R8: only reset clears the sticky flag
        do_reset("R8");
        idle("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule